// File: doc/BRIEF.md
# Inter-Core Interrupt Mailbox Unit

A shared unit through which any of `NCORE` cores (four by default) raises an interrupt on another core. Each core owns one interrupt line. Behind every line sits a pending-source bitmask with one bit for each possible sender. A core sends a command by pulsing a strobe together with its own core number, a two-bit opcode and a core-number parameter. Results of query commands appear on a registered readback word one cycle later.

Pending state is kept per sender. When several cores interrupt the same target close together, their requests merge into one asserted line. The target then reads the source mask, which may have more than one bit set, and acknowledges each sender separately. A repeated request from a sender that is already pending is absorbed and is not counted. A core cannot interrupt itself through the unit.

Top module: `icmb_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, every interrupt line is low, every pending mask is empty and `rd_valid` is low.
- R2: A raise command (opcode 0) from core s with parameter t, where t differs from s, sets bit s of core t's pending mask. `irq_o[t]` is high from the cycle after the command.
- R3: A raise command whose parameter equals the issuing core changes no pending mask and no interrupt line.
- R4: A raise command for a sender bit that is already pending leaves the state as it is. A single acknowledge then clears that bit.
- R5: A status command (opcode 1) with parameter t returns 1 on `rd_data` when core t has any pending bit, and 0 otherwise. The value reflects the state before the command.
- R6: A source command (opcode 2) returns on `rd_data` the issuing core's pending mask. Bit i is set when core i has an interrupt pending toward the issuer.
- R7: Raise commands from several senders to one target accumulate as separate bits of that target's mask, behind one asserted line.
- R8: An acknowledge command (opcode 3) with parameter s clears only bit s of the issuing core's mask. The issuer's line stays high while other bits remain, and falls the cycle after the last bit is cleared. No other core's mask changes.
- R9: An acknowledge naming a sender whose bit is not pending changes no state.
- R10: `rd_valid` is high for exactly the one cycle after a status or source command. It is low after raise and acknowledge commands and when no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | Opcode: 0 raise, 1 status, 2 source, 3 acknowledge |
| cmd_core | input | IDW | Number of the issuing core |
| cmd_param | input | IDW | Target core (raise, status) or sender core (acknowledge) |
| rd_data | output | DW | Readback word for status and source commands |
| rd_valid | output | 1 | Readback word is valid in this cycle |
| irq_o | output | NCORE | One interrupt line per core |

## Verification
The bench concentrates on how senders merge into a target's mask. Three cores interrupt one target. The mask must show all three bits, and the line must survive two partial acknowledges before it falls. A design that cleared the whole mask on any acknowledge would drop the line early. A design that kept a single flag per target would return the wrong source mask. The bench also checks that a self-addressed raise does nothing, since a missing guard would light the issuer's own line. It checks that a duplicate raise needs only one acknowledge, which a counting design would fail. It checks that an acknowledge naming a sender that is not pending leaves other senders' bits intact. Finally, readback is sampled one cycle after each query to catch a wrong latency or a value taken after the update.

// File: rtl/icmb_pkg.sv
package icmb_pkg;

    typedef enum logic [1:0] {
        OP_RAISE = 2'd0,
        OP_PEEK  = 2'd1,
        OP_WHO   = 2'd2,
        OP_CLEAR = 2'd3
    } icmb_op_e;

    typedef struct packed {
        logic raise;
        logic peek;
        logic who;
        logic clear;
    } icmb_dec_t;

    function automatic icmb_dec_t decode_op(input logic valid, input icmb_op_e op);
        icmb_dec_t d;
        d.raise = valid && (op == OP_RAISE);
        d.peek  = valid && (op == OP_PEEK);
        d.who   = valid && (op == OP_WHO);
        d.clear = valid && (op == OP_CLEAR);
        return d;
    endfunction

endpackage

// File: rtl/icmb_decode.sv
module icmb_decode
    import icmb_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int IDW   = $clog2(NCORE)
) (
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [IDW-1:0]   cmd_core,
    input  logic [IDW-1:0]   cmd_param,
    output icmb_dec_t        dec,
    output logic [NCORE-1:0] set_row,
    output logic [NCORE-1:0] clr_row,
    output logic [NCORE-1:0] src_hot,
    output logic [NCORE-1:0] par_hot
);

    logic core_ok;
    logic par_ok;

    always_comb begin
        dec     = decode_op(cmd_valid, icmb_op_e'(cmd_op));
        core_ok = (int'(cmd_core) < NCORE);
        par_ok  = (int'(cmd_param) < NCORE);
    end

    genvar g;
    generate
        for (g = 0; g < NCORE; g++) begin : g_hot
            assign src_hot[g] = core_ok && (int'(cmd_core) == g);
            assign par_hot[g] = par_ok && (int'(cmd_param) == g);
            // raise lands on the row of the target, never on the issuer itself
            assign set_row[g] = dec.raise && par_hot[g] && !src_hot[g];
            // acknowledge works on the issuer's own row
            assign clr_row[g] = dec.clear && src_hot[g] && par_ok;
        end
    endgenerate

endmodule

// File: rtl/icmb_pend_bank.sv
module icmb_pend_bank #(
    parameter int NCORE = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NCORE-1:0]            set_row,
    input  logic [NCORE-1:0]            clr_row,
    input  logic [NCORE-1:0]            src_hot,
    input  logic [NCORE-1:0]            par_hot,
    output logic [NCORE-1:0][NCORE-1:0] pend,
    output logic [NCORE-1:0]            irq
);

    genvar t;
    generate
        for (t = 0; t < NCORE; t++) begin : g_row
            logic [NCORE-1:0] row_next;

            always_comb begin
                row_next = pend[t];
                if (set_row[t]) row_next = row_next | src_hot;
                if (clr_row[t]) row_next = row_next & ~par_hot;
            end

            always_ff @(posedge clk) begin
                if (rst) pend[t] <= '0;
                else     pend[t] <= row_next;
            end

            assign irq[t] = |pend[t];
        end
    endgenerate

endmodule

// File: rtl/icmb_readback.sv
module icmb_readback
    import icmb_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int IDW   = $clog2(NCORE),
    parameter int DW    = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  icmb_dec_t                   dec,
    input  logic [IDW-1:0]              cmd_core,
    input  logic [IDW-1:0]              cmd_param,
    input  logic [NCORE-1:0][NCORE-1:0] pend,
    output logic [DW-1:0]               rd_data,
    output logic                        rd_valid
);

    logic [DW-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (dec.peek && int'(cmd_param) < NCORE)
            rd_next[0] = |pend[cmd_param];
        else if (dec.who && int'(cmd_core) < NCORE)
            rd_next[NCORE-1:0] = pend[cmd_core];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= dec.peek || dec.who;
            if (dec.peek || dec.who) rd_data <= rd_next;
        end
    end

endmodule

// File: rtl/icmb_unit.sv
module icmb_unit
    import icmb_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int IDW   = $clog2(NCORE),
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [IDW-1:0]   cmd_core,
    input  logic [IDW-1:0]   cmd_param,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic [NCORE-1:0] irq_o
);

    icmb_dec_t                   dec;
    logic [NCORE-1:0]            set_row;
    logic [NCORE-1:0]            clr_row;
    logic [NCORE-1:0]            src_hot;
    logic [NCORE-1:0]            par_hot;
    logic [NCORE-1:0][NCORE-1:0] pend;

    icmb_decode #(.NCORE(NCORE), .IDW(IDW)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_core  (cmd_core),
        .cmd_param (cmd_param),
        .dec       (dec),
        .set_row   (set_row),
        .clr_row   (clr_row),
        .src_hot   (src_hot),
        .par_hot   (par_hot)
    );

    icmb_pend_bank #(.NCORE(NCORE)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_row (set_row),
        .clr_row (clr_row),
        .src_hot (src_hot),
        .par_hot (par_hot),
        .pend    (pend),
        .irq     (irq_o)
    );

    icmb_readback #(.NCORE(NCORE), .IDW(IDW), .DW(DW)) u_rb (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .cmd_core  (cmd_core),
        .cmd_param (cmd_param),
        .pend      (pend),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/icmb_chk.sv
module icmb_chk #(
    parameter int NCORE = 4,
    parameter int IDW   = $clog2(NCORE),
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [IDW-1:0]   cmd_core,
    input logic [IDW-1:0]   cmd_param,
    input logic [DW-1:0]    rd_data,
    input logic             rd_valid,
    input logic [NCORE-1:0] irq_o
);

    logic is_peek, is_who, is_raise, is_clear;
    assign is_raise = cmd_valid && cmd_op == 2'd0;
    assign is_peek  = cmd_valid && cmd_op == 2'd1;
    assign is_who   = cmd_valid && cmd_op == 2'd2;
    assign is_clear = cmd_valid && cmd_op == 2'd3;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (irq_o == '0 && !rd_valid));

    // R2
    raise_sets_line_chk: assert property (@(posedge clk) disable iff (rst)
        (is_raise && cmd_core != cmd_param) |=> irq_o[$past(cmd_param)]);

    // R3
    self_raise_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (is_raise && cmd_core == cmd_param) |=> $stable(irq_o));

    // R5
    peek_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (is_peek && !irq_o[cmd_param]) |=> rd_data == '0);

    // R5
    peek_busy_one_chk: assert property (@(posedge clk) disable iff (rst)
        (is_peek && irq_o[cmd_param]) |=> rd_data == DW'(1));

    // R6
    who_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (is_who && !irq_o[cmd_core]) |=> rd_data == '0);

    // R8
    clear_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        is_clear |=> (irq_o & ~$past(irq_o)) == '0);

    // R10
    rdv_query_chk: assert property (@(posedge clk) disable iff (rst)
        (is_peek || is_who) |=> rd_valid);

    // R10
    rdv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(is_peek || is_who) |=> !rd_valid);

endmodule

bind icmb_unit icmb_chk #(.NCORE(NCORE), .IDW(IDW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_core  (cmd_core),
    .cmd_param (cmd_param),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .irq_o     (irq_o)
);

// File: tb/icmb_unit_tb.sv
module icmb_unit_tb_top;

    localparam int NCORE = 4;
    localparam int IDW   = 2;
    localparam int DW    = 32;

    localparam logic [1:0] RAISE = 2'd0;
    localparam logic [1:0] PEEK  = 2'd1;
    localparam logic [1:0] WHO   = 2'd2;
    localparam logic [1:0] CLEAR = 2'd3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = '0;
    logic [IDW-1:0]   cmd_core = '0;
    logic [IDW-1:0]   cmd_param = '0;
    logic [DW-1:0]    rd_data;
    logic             rd_valid;
    logic [NCORE-1:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    icmb_unit #(.NCORE(NCORE), .IDW(IDW), .DW(DW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_core  (cmd_core),
        .cmd_param (cmd_param),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at a falling edge; outputs are read at the next falling edge
    task automatic cmd(input logic [1:0] op, input int core, input int param);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_core  = IDW'(core);
        cmd_param = IDW'(param);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic who(input int core, input logic [3:0] exp, input string req);
        cmd(WHO, core, 0);
        check(req, {31'd0, rd_valid}, 32'd1);
        check(req, rd_data, {28'd0, exp});
    endtask

    task automatic t_reset;
        check("R1 irq", {28'd0, irq_o}, 32'd0);
        check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        for (int c = 0; c < NCORE; c++) who(c, 4'b0000, "R1 mask");
    endtask

    task automatic t_basic;
        cmd(RAISE, 1, 2);
        check("R2 irq", {28'd0, irq_o}, 32'b0100);
        check("R10 no rdv after raise", {31'd0, rd_valid}, 32'd0);
        cmd(PEEK, 0, 2);
        check("R5 busy", rd_data, 32'd1);
        check("R10 rdv peek", {31'd0, rd_valid}, 32'd1);
        @(negedge clk);
        check("R10 rdv one cycle", {31'd0, rd_valid}, 32'd0);
        cmd(PEEK, 0, 3);
        check("R5 idle", rd_data, 32'd0);
        who(2, 4'b0010, "R6 source");
        cmd(CLEAR, 2, 1);
        check("R8 clear", {28'd0, irq_o}, 32'd0);
        check("R10 no rdv after ack", {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic t_self;
        cmd(RAISE, 3, 3);
        check("R3 irq", {28'd0, irq_o}, 32'd0);
        who(3, 4'b0000, "R3 mask");
    endtask

    task automatic t_coalesce;
        cmd(RAISE, 0, 2);
        cmd(RAISE, 1, 2);
        cmd(RAISE, 3, 2);
        check("R7 one line", {28'd0, irq_o}, 32'b0100);
        who(2, 4'b1011, "R7 merged mask");
        cmd(CLEAR, 2, 0);
        check("R8 line held", {28'd0, irq_o}, 32'b0100);
        who(2, 4'b1010, "R8 partial");
        cmd(CLEAR, 2, 3);
        who(2, 4'b0010, "R8 partial2");
        check("R8 line held2", {28'd0, irq_o}, 32'b0100);
        cmd(CLEAR, 2, 1);
        check("R8 last ack drops", {28'd0, irq_o}, 32'd0);
    endtask

    task automatic t_dup;
        cmd(RAISE, 0, 1);
        cmd(RAISE, 0, 1);
        who(1, 4'b0001, "R4 mask");
        cmd(CLEAR, 1, 0);
        check("R4 single ack", {28'd0, irq_o}, 32'd0);
    endtask

    task automatic t_stray_ack;
        cmd(RAISE, 2, 0);
        cmd(CLEAR, 0, 3);
        check("R9 irq", {28'd0, irq_o}, 32'b0001);
        who(0, 4'b0100, "R9 mask");
        cmd(CLEAR, 0, 2);
        check("R9 cleanup", {28'd0, irq_o}, 32'd0);
    endtask

    task automatic t_fanout;
        cmd(RAISE, 0, 1);
        cmd(RAISE, 0, 2);
        cmd(RAISE, 0, 3);
        check("R2 fanout", {28'd0, irq_o}, 32'b1110);
        cmd(CLEAR, 1, 0);
        check("R8 own row only", {28'd0, irq_o}, 32'b1100);
        who(3, 4'b0001, "R8 other row kept");
        cmd(CLEAR, 2, 0);
        cmd(CLEAR, 3, 0);
        check("R8 all clear", {28'd0, irq_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_self();
        t_coalesce();
        t_dup();
        t_stray_ack();
        t_fanout();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule